// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds a general-purpose register file that is split into overlapping register windows arranged as a ring. Software only ever names 32 registers. A window pointer picks which physical entries stand behind those names. Registers 0 to 7 are shared by every window. Registers 24 to 31 are the incoming arguments of the current window. Registers 16 to 23 are its private scratch registers. Registers 8 to 15 are its outgoing arguments, and they are physically the same entries as the incoming registers of the next window around the ring. A call advances the pointer so that the callee gets fresh private registers and sees its caller's outgoing values as its own inputs. A return moves the pointer back. No data is copied in either case.

A bit mask marks the windows whose contents currently sit in memory. A call whose target window is marked does not move the pointer. It raises a one-cycle spill trap instead. A return whose target is marked raises a fill trap in the same way. The trap handler moves the data itself, outside this block, and then pulses a save or restore strobe. The strobe shifts the marked window along the ring, so the faulting call or return can be issued again and now succeeds. The block has two combinational read ports and one write port. Both read ports see a write made in the same cycle.

Top module: `regwin_ctrl`

## Requirements
- R1: Logical register 0 reads as zero on both read ports at all times, including in a cycle that writes it. A write to it changes nothing.
- R2: A value written to a logical register is read back from that register while the same window is current. Private registers 16–23 of different windows are separate storage.
- R3: A call into a valid window sets the pointer to (pointer+1) mod NWIN at the next clock edge. After the call, the callee's registers 24+k read what the caller wrote to registers 8+k, for k in 0..7.
- R4: A return into a valid window sets the pointer to (pointer−1) mod NWIN at the next clock edge. The caller's private registers and outgoing registers still hold the values it wrote before the call.
- R5: Registers 1–7 are the same storage in every window.
- R6: A call whose target window is marked invalid leaves the pointer unchanged and raises spill_trap_o for exactly the one cycle after the edge. After reset only window NWIN−1 is marked.
- R7: A return whose target window is marked invalid leaves the pointer unchanged and raises fill_trap_o for exactly the one cycle after the edge.
- R8: A save strobe unmarks window (pointer+1) mod NWIN and marks (pointer+2) mod NWIN. A restore strobe unmarks (pointer−1) mod NWIN and marks (pointer−2) mod NWIN. Exactly one window is always marked, and a retried call or return then completes.
- R9: When a read port addresses the same physical entry that the write port writes in the same cycle, it returns the write data.
- R10: Save and restore take precedence over call and return in the same cycle. If save and restore arrive together, or call and return arrive together, neither of the pair has any effect. The pointer wraps in both directions.
- R11: After reset the pointer is 0 and both trap outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Procedure-call strobe |
| ret_i | input | 1 | Procedure-return strobe |
| save_i | input | 1 | Handler finished spilling a window |
| restore_i | input | 1 | Handler finished filling a window |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Logical register to write |
| wr_data_i | input | XLEN | Write data |
| rd_a_idx_i | input | 5 | Logical register for read port A |
| rd_a_data_o | output | XLEN | Read port A data |
| rd_b_idx_i | input | 5 | Logical register for read port B |
| rd_b_data_o | output | XLEN | Read port B data |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| spill_trap_o | output | 1 | Call blocked by a window held in memory |
| fill_trap_o | output | 1 | Return blocked by a window held in memory |

## Verification
The scoreboard targets the seam between windows. A callee's input registers must show the caller's output registers, and a mapping off by one window would show stale or foreign values there. It drives the pointer up to the marked window and then around the ring through index 0 in both directions. A design with a wrong modulo step would trap too early, or would step the pointer onto the marked window instead of holding it. It issues call and return together, and strobes together with a call or return, and checks that the pointer and the traps ignore the losing request. It also reads an entry in the cycle it is written and reads register 0 in a cycle that writes it, which exposes a missing forward path and a forward that leaks into register 0.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int LREG_BITS = 5;
    localparam int GLB_N     = 8;
    localparam int GRP_N     = 8;
    localparam int WIN_SLOTS = 2 * GRP_N;

    typedef logic [LREG_BITS-1:0] lreg_t;

    // Group order follows the two top bits of the logical register number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;

    function automatic grp_e grp_of(lreg_t r);
        return grp_e'(r[4:3]);
    endfunction
endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [CW-1:0] cwp_i,
    input  lreg_t         lreg_i,
    output logic [PW-1:0] phys_o
);
    logic [CW-1:0] nxt_w;
    int            base_cur;
    int            base_nxt;
    int            ofs;

    always_comb begin
        nxt_w    = (cwp_i == CW'(NWIN - 1)) ? '0 : cwp_i + 1'b1;
        base_cur = GLB_N + int'(cwp_i) * WIN_SLOTS;
        base_nxt = GLB_N + int'(nxt_w) * WIN_SLOTS;
        ofs      = int'(lreg_i[2:0]);
        unique case (grp_of(lreg_i))
            GRP_GLOBAL: phys_o = PW'(ofs);
            GRP_OUT:    phys_o = PW'(base_nxt + GRP_N + ofs);
            GRP_LOCAL:  phys_o = PW'(base_cur + ofs);
            GRP_IN:     phys_o = PW'(base_cur + GRP_N + ofs);
            default:    phys_o = '0;
        endcase
    end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [CW-1:0] cwp_o,
    output logic          spill_o,
    output logic          fill_o
);
    typedef struct packed {
        logic [CW-1:0]   cwp;
        logic [NWIN-1:0] wim;
        logic            spill;
        logic            fill;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [CW-1:0] nxt1, nxt2, prv1, prv2;

    function automatic logic [CW-1:0] ring_inc(logic [CW-1:0] v);
        return (v == CW'(NWIN - 1)) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [CW-1:0] ring_dec(logic [CW-1:0] v);
        return (v == '0) ? CW'(NWIN - 1) : v - 1'b1;
    endfunction

    always_comb begin
        nxt1 = ring_inc(st_q.cwp);
        nxt2 = ring_inc(nxt1);
        prv1 = ring_dec(st_q.cwp);
        prv2 = ring_dec(prv1);

        st_d       = st_q;
        st_d.spill = 1'b0;
        st_d.fill  = 1'b0;

        if (save_i || restore_i) begin
            if (save_i && !restore_i) begin
                st_d.wim[nxt1] = 1'b0;
                st_d.wim[nxt2] = 1'b1;
            end else if (restore_i && !save_i) begin
                st_d.wim[prv1] = 1'b0;
                st_d.wim[prv2] = 1'b1;
            end
        end else if (call_i && !ret_i) begin
            if (st_q.wim[nxt1]) st_d.spill = 1'b1;
            else                st_d.cwp   = nxt1;
        end else if (ret_i && !call_i) begin
            if (st_q.wim[prv1]) st_d.fill = 1'b1;
            else                st_d.cwp  = prv1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cwp   <= '0;
            st_q.wim   <= {1'b1, {(NWIN-1){1'b0}}};
            st_q.spill <= 1'b0;
            st_q.fill  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp_o   = st_q.cwp;
    assign spill_o = st_q.spill;
    assign fill_o  = st_q.fill;

    AST_SPILL_HOLDS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.spill |-> (st_q.cwp == $past(st_q.cwp))); // R6
    AST_FILL_HOLDS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill |-> (st_q.cwp == $past(st_q.cwp))); // R7
    AST_TRAPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.spill && st_q.fill)); // R6
    AST_SINGLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.wim) == 1); // R8
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cwp <= CW'(NWIN - 1)); // R10
    AST_MOVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cwp != $past(st_q.cwp)) |-> $past(call_i || ret_i)); // R3
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 136,
    parameter int PW    = 8
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [PW-1:0]   waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [PW-1:0]   raddr_a_i,
    input  logic [PW-1:0]   raddr_b_i,
    output logic [XLEN-1:0] rdata_a_o,
    output logic [XLEN-1:0] rdata_b_o
);
    logic [XLEN-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    always_comb begin
        rdata_a_o = (we_i && waddr_i == raddr_a_i) ? wdata_i : mem_q[raddr_a_i];
        rdata_b_o = (we_i && waddr_i == raddr_b_i) ? wdata_i : mem_q[raddr_b_i];
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter  int NWIN  = 8,
    parameter  int XLEN  = 32,
    localparam int CW    = $clog2(NWIN),
    localparam int DEPTH = GLB_N + NWIN * WIN_SLOTS,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic            wr_en_i,
    input  logic [4:0]      wr_idx_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic [4:0]      rd_a_idx_i,
    output logic [XLEN-1:0] rd_a_data_o,
    input  logic [4:0]      rd_b_idx_i,
    output logic [XLEN-1:0] rd_b_data_o,
    output logic [CW-1:0]   cwp_o,
    output logic            spill_trap_o,
    output logic            fill_trap_o
);
    logic [CW-1:0]   cwp_w;
    lreg_t           lreg_w [3];
    logic [PW-1:0]   phys_w [3];
    logic            store_we;
    logic [XLEN-1:0] raw_a, raw_b;

    assign lreg_w[0] = wr_idx_i;
    assign lreg_w[1] = rd_a_idx_i;
    assign lreg_w[2] = rd_b_idx_i;

    regwin_ptr #(.NWIN(NWIN), .CW(CW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .save_i    (save_i),
        .restore_i (restore_i),
        .cwp_o     (cwp_w),
        .spill_o   (spill_trap_o),
        .fill_o    (fill_trap_o)
    );

    for (genvar p = 0; p < 3; p++) begin : g_map
        regwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .cwp_i  (cwp_w),
            .lreg_i (lreg_w[p]),
            .phys_o (phys_w[p])
        );
    end

    assign store_we = wr_en_i && (wr_idx_i != '0);

    regwin_store #(.XLEN(XLEN), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk       (clk),
        .we_i      (store_we),
        .waddr_i   (phys_w[0]),
        .wdata_i   (wr_data_i),
        .raddr_a_i (phys_w[1]),
        .raddr_b_i (phys_w[2]),
        .rdata_a_o (raw_a),
        .rdata_b_o (raw_b)
    );

    assign rd_a_data_o = (rd_a_idx_i == '0) ? '0 : raw_a;
    assign rd_b_data_o = (rd_b_idx_i == '0) ? '0 : raw_b;
    assign cwp_o       = cwp_w;

    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == '0) |-> (rd_a_data_o == '0)); // R1
    AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we && phys_w[0] == phys_w[1] && rd_a_idx_i != '0)
            |-> (rd_a_data_o == wr_data_i)); // R9
endmodule

// File: tb/sim_regwin_ctrl.sv
module sim_regwin_ctrl;
    localparam int NWIN = 8;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            call_s = 0, ret_s = 0, save_s = 0, rest_s = 0, wr_en = 0;
    logic [4:0]      wr_idx = '0, ra_idx = '0, rb_idx = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [XLEN-1:0] ra_data, rb_data;
    logic [2:0]      cwp;
    logic            spill, fill;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int          due;
        int          kind;   // 0 port A, 1 port B, 2 pointer, 3 spill, 4 fill
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t sb[$];

    regwin_ctrl #(.NWIN(NWIN), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .call_i(call_s), .ret_i(ret_s),
        .save_i(save_s), .restore_i(rest_s), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .rd_a_idx_i(ra_idx), .rd_a_data_o(ra_data),
        .rd_b_idx_i(rb_idx), .rd_b_data_o(rb_data),
        .cwp_o(cwp), .spill_trap_o(spill), .fill_trap_o(fill)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pick(int kind);
        case (kind)
            0: return ra_data;
            1: return rb_data;
            2: return {29'd0, cwp};
            3: return {31'd0, spill};
            default: return {31'd0, fill};
        endcase
    endfunction

    // monitor: compares every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [31:0] act;
                act = pick(sb[i].kind);
                total++;
                if (act !== sb[i].val) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             sb[i].tag, sb[i].kind, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(int kind, int ahead, logic [31:0] v, string tag);
        item_t it;
        it.due = cyc + ahead; it.kind = kind; it.val = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        call_s = 0; ret_s = 0; save_s = 0; rest_s = 0; wr_en = 0;
    endtask

    task automatic wr(logic [4:0] idx, logic [31:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
    endtask

    task automatic rda(logic [4:0] idx, logic [31:0] e, string tag);
        ra_idx = idx; push(0, 0, e, tag);
    endtask

    task automatic rdb(logic [4:0] idx, logic [31:0] e, string tag);
        rb_idx = idx; push(1, 0, e, tag);
    endtask

    task automatic ptr_next(int p, logic sp, logic fl, string tag);
        push(2, 1, p, tag); push(3, 1, {31'd0, sp}, tag); push(4, 1, {31'd0, fl}, tag);
    endtask

    initial begin
        #(20 * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        push(2, 0, 0, "R11 reset pointer"); push(3, 0, 0, "R11 reset spill");
        push(4, 0, 0, "R11 reset fill");
        tick();
        wr(0, 32'hDEAD_BEEF); rda(0, 0, "R1 zero same cycle A"); rdb(0, 0, "R1 zero same cycle B");
        tick();
        wr(16, 32'h1000_0010); tick();
        wr(8, 32'h0000_00A8); tick();
        wr(1, 32'h0000_600D); rda(16, 32'h1000_0010, "R2 local readback"); tick();
        rda(0, 0, "R1 zero after write"); rdb(8, 32'hA8, "R2 out readback"); tick();
        call_s = 1; ptr_next(1, 0, 0, "R3 call advances"); tick();
        rda(24, 32'hA8, "R3 callee in = caller out"); rdb(1, 32'h600D, "R5 global shared");
        wr(16, 32'h11); tick();
        rda(16, 32'h11, "R2 callee local"); wr(8, 32'hB8); tick();
        ret_s = 1; ptr_next(0, 0, 0, "R4 return steps back"); tick();
        rda(16, 32'h1000_0010, "R4 caller local intact"); rdb(8, 32'hA8, "R4 caller out intact"); tick();
        wr(20, 32'h55); rda(20, 32'h55, "R9 forward A"); rdb(20, 32'h55, "R9 forward B"); tick();
        wr(20, 32'h66); rda(20, 32'h66, "R9 forward over old"); tick();
        rdb(20, 32'h66, "R2 stored after forward"); tick();
        for (int i = 1; i <= 6; i++) begin
            call_s = 1; ptr_next(i, 0, 0, "R3 call chain"); tick();
        end
        call_s = 1; ptr_next(6, 1, 0, "R6 spill on marked window"); tick();
        ptr_next(6, 0, 0, "R6 spill is one pulse"); tick();
        call_s = 1; ret_s = 1; ptr_next(6, 0, 0, "R10 call with return ignored"); tick();
        save_s = 1; call_s = 1; ptr_next(6, 0, 0, "R10 save beats call"); tick();
        call_s = 1; ptr_next(7, 0, 0, "R8 retry after save"); tick();
        call_s = 1; ptr_next(7, 1, 0, "R8 save marked ptr+2"); tick();
        save_s = 1; tick();
        call_s = 1; ptr_next(0, 0, 0, "R10 wrap upward"); tick();
        ret_s = 1; ptr_next(7, 0, 0, "R10 wrap downward"); tick();
        for (int p = 6; p >= 2; p--) begin
            ret_s = 1; ptr_next(p, 0, 0, "R4 return chain"); tick();
        end
        ret_s = 1; ptr_next(2, 0, 1, "R7 fill on marked window"); tick();
        rest_s = 1; ret_s = 1; ptr_next(2, 0, 0, "R10 restore beats return"); tick();
        ret_s = 1; ptr_next(1, 0, 0, "R8 retry after restore"); tick();
        ret_s = 1; ptr_next(1, 0, 1, "R8 restore marked ptr-2"); tick();
        tick(); tick();
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule